// File: doc/BRIEF.md
# Programmable-Component 128-bit Block Encryption Core

This core encrypts one 128-bit block under a 128-bit key. It follows the ten-round structure of AES-128, with three differences. The byte substitution table, the byte shuffle and the four coefficients of the circulant column-mixing matrix are not fixed. They are held in registers and written at run time through a small configuration port. The on-the-fly round-key expansion looks up the same loaded table.

Configuration writes carry a selector, an address and a data byte. A run starts with a single-cycle `start` strobe that presents the plaintext and the key. The core works one round per clock. It raises `done` for one cycle and leaves the ciphertext on its output until the next accepted start. A configuration that cannot work raises `cfg_err`: the shuffle may send two bytes to one place, or a zero coefficient may have been offered. While `cfg_err` is high the core refuses to start.

Top module: `aclc_cipher_core`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `cfg_err` are 0 and `ciphertext` is all zero. The table maps every byte to itself, the shuffle is the identity, and the coefficients are a=2, b=3, c=1, d=1.
- R2: State byte i (0..15) is bits [127-8i -: 8] of `plaintext`, `key` and `ciphertext`, and byte 4c+r is row r of column c. The plaintext is XORed with the key once before round 1.
- R3: With `cfg_sel`=0, a write stores `cfg_data` as the table entry for input value `cfg_addr`. The substitution layer replaces every state byte through this table.
- R4: With `cfg_sel`=1, a write sets the destination of source byte `cfg_addr[3:0]` to `cfg_data[3:0]`. The shuffle moves the byte at source position s to position dst[s].
- R5: With `cfg_sel`=2, a write of a nonzero `cfg_data` sets coefficient `cfg_addr[1:0]` (0=a, 1=b, 2=c, 3=d). Each column is multiplied in GF(2^8) (polynomial 0x11B) by the matrix with rows (a b c d), (d a b c), (c d a b), (b c d a).
- R6: A coefficient write with data 0 leaves the coefficient unchanged and raises `cfg_err`. The next accepted nonzero coefficient write clears that cause.
- R7: `cfg_err` is high whenever two shuffle entries name the same destination. While `cfg_err` is high, `start` is ignored: `busy` stays 0 and `ciphertext` is unchanged.
- R8: A start accepted at clock edge k drives `busy` high from edge k to edge k+10. `done` is high for exactly the one cycle after edge k+10, and `ciphertext` then holds its value until the next accepted start.
- R9: Rounds 1..9 apply substitution, shuffle, column mixing and round-key addition, in that order. Round 10 leaves out the mixing. Round keys follow the AES-128 expansion, with the loaded table in place of the S-box and round constants 01,02,04,08,10,20,40,80,1B,36. With the standard table and row-shift shuffle loaded, plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R10: While `busy` is high, configuration writes and `start` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 table, 1 shuffle, 2 coefficient |
| cfg_addr | input | 8 | Table index, shuffle source or coefficient index |
| cfg_data | input | 8 | Value to write |
| cfg_err | output | 1 | Configuration unusable; start refused |
| start | input | 1 | Start strobe, one cycle |
| plaintext | input | 128 | Block to encrypt, sampled with start |
| key | input | 128 | Cipher key, sampled with start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| ciphertext | output | 128 | Result, held until the next accepted start |

## Verification
The hardest situations to reach from the ports involve configuration changes that arrive at the wrong moment. One is a write or start strobe that lands in the middle of a run. Another is a configuration that fails only through a duplicate shuffle destination. The stimulus presses start and writes a table entry and a coefficient while `busy` is high. It then runs a fresh encryption whose result shows whether those writes leaked in. It also corrupts one shuffle entry to collide with another, tries to start, and repairs the entry. A zero coefficient is offered between two runs, so the following result reveals whether the old coefficient survived.

// File: rtl/aclc_pkg.sv
// Shared constants and GF(2^8) helpers for the programmable block cipher.
// Assumes the field reduction polynomial x^8+x^4+x^3+x+1.
package aclc_pkg;
    localparam int BYTE_W    = 8;
    localparam int N_BYTES   = 16;
    localparam int N_ROWS    = 4;
    localparam int N_COLS    = N_BYTES / N_ROWS;
    localparam int TBL_DEPTH = 1 << BYTE_W;
    localparam int N_ROUNDS  = 10;
    localparam int IDX_W     = $clog2(N_BYTES);
    localparam int RND_W     = $clog2(N_ROUNDS + 1);
    localparam int COEF_W    = $clog2(N_ROWS);

    localparam logic [1:0] SEL_TABLE = 2'd0;
    localparam logic [1:0] SEL_PERM  = 2'd1;
    localparam logic [1:0] SEL_COEF  = 2'd2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Multiply by x modulo the field polynomial.
    function automatic byte_t xtime(byte_t x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    endfunction

    // Full field multiply by shift-and-add.
    function automatic byte_t gf_mul(byte_t x, byte_t y);
        byte_t acc = '0;
        byte_t p   = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // Round constant for round r (1-based): x^(r-1).
    function automatic byte_t rcon_of(logic [RND_W-1:0] r);
        byte_t v = 8'h01;
        for (int i = 1; i < N_ROUNDS; i++) begin
            if (RND_W'(i) < r) v = xtime(v);
        end
        return v;
    endfunction
endpackage

// File: rtl/aclc_cfg_store.sv
// Configuration registers: substitution table, shuffle destinations and
// matrix coefficients, plus the unusable-configuration flag.
// Assumes writes are blocked by the caller-supplied lock while a run is active.
module aclc_cfg_store
    import aclc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [7:0]        addr,
    input  logic [7:0]        data,
    input  logic              lock,
    output byte_t             tbl  [TBL_DEPTH],
    output logic [IDX_W-1:0]  dst  [N_BYTES],
    output byte_t             coef [N_ROWS],
    output logic              err
);
    logic          wr_ok;
    logic          zero_seen;
    logic [N_BYTES-1:0] hit;

    assign wr_ok = we && !lock;

    // Table storage: identity at reset, byte writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= BYTE_W'(i);
        end else if (wr_ok && sel == SEL_TABLE) begin
            tbl[addr] <= data;
        end
    end

    // Shuffle destinations: identity at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) dst[i] <= IDX_W'(i);
        end else if (wr_ok && sel == SEL_PERM) begin
            dst[addr[IDX_W-1:0]] <= data[IDX_W-1:0];
        end
    end

    // Coefficients: nonzero writes only; zero writes mark the error cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef[0]   <= 8'h02;
            coef[1]   <= 8'h03;
            coef[2]   <= 8'h01;
            coef[3]   <= 8'h01;
            zero_seen <= 1'b0;
        end else if (wr_ok && sel == SEL_COEF) begin
            zero_seen <= (data == '0);
            if (data != '0) coef[addr[COEF_W-1:0]] <= data;
        end
    end

    // Destination coverage: every position must be hit exactly once.
    always_comb begin
        hit = '0;
        for (int s = 0; s < N_BYTES; s++) hit = hit | (N_BYTES'(1) << dst[s]);
    end

    assign err = zero_seen || !(&hit);

    p_zero_coef_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == SEL_COEF && data == 8'h00) |=> err);
    p_coef_never_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (coef[0] != 8'h00 && coef[1] != 8'h00 && coef[2] != 8'h00 && coef[3] != 8'h00));
endmodule

// File: rtl/aclc_mix_col.sv
// One column of the circulant mixing layer. Output row r is the sum over k
// of coef[(k - r) mod 4] * in[k]. Assumes nonzero coefficients.
module aclc_mix_col
    import aclc_pkg::*;
(
    input  byte_t col_in  [N_ROWS],
    input  byte_t coef    [N_ROWS],
    output byte_t col_out [N_ROWS]
);
    // Field dot product of each matrix row with the column.
    always_comb begin
        for (int r = 0; r < N_ROWS; r++) begin
            col_out[r] = '0;
            for (int k = 0; k < N_ROWS; k++) begin
                col_out[r] = col_out[r]
                           ^ gf_mul(coef[(k - r + N_ROWS) % N_ROWS], col_in[k]);
            end
        end
    end
endmodule

// File: rtl/aclc_round.sv
// Combinational round: next round key, substitution, shuffle, optional
// mixing, key addition. Assumes rnd is 1..N_ROUNDS and dst is a permutation.
module aclc_round
    import aclc_pkg::*;
(
    input  byte_t             state_in [N_BYTES],
    input  byte_t             rk_in    [N_BYTES],
    input  byte_t             tbl      [TBL_DEPTH],
    input  logic [IDX_W-1:0]  dst      [N_BYTES],
    input  byte_t             coef     [N_ROWS],
    input  logic [RND_W-1:0]  rnd,
    input  logic              last,
    output byte_t             state_out[N_BYTES],
    output byte_t             rk_out   [N_BYTES]
);
    byte_t sub_b  [N_BYTES];
    byte_t shuf_b [N_BYTES];
    byte_t mix_b  [N_BYTES];
    byte_t kword  [N_ROWS];

    // Key expansion step: rotated, substituted last word plus round constant.
    always_comb begin
        for (int r = 0; r < N_ROWS; r++)
            kword[r] = tbl[rk_in[(N_COLS-1)*N_ROWS + (r + 1) % N_ROWS]];
        kword[0] = kword[0] ^ rcon_of(rnd);
        for (int r = 0; r < N_ROWS; r++) rk_out[r] = rk_in[r] ^ kword[r];
        for (int c = 1; c < N_COLS; c++)
            for (int r = 0; r < N_ROWS; r++)
                rk_out[c*N_ROWS + r] = rk_in[c*N_ROWS + r] ^ rk_out[(c-1)*N_ROWS + r];
    end

    // Substitution through the loaded table.
    always_comb begin
        for (int i = 0; i < N_BYTES; i++) sub_b[i] = tbl[state_in[i]];
    end

    // Shuffle: gather, for each destination, the source that names it.
    always_comb begin
        for (int j = 0; j < N_BYTES; j++) begin
            shuf_b[j] = '0;
            for (int s = 0; s < N_BYTES; s++)
                if (dst[s] == IDX_W'(j)) shuf_b[j] = shuf_b[j] | sub_b[s];
        end
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        byte_t cin  [N_ROWS];
        byte_t cout [N_ROWS];
        for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            assign cin[r] = shuf_b[c*N_ROWS + r];
            assign mix_b[c*N_ROWS + r] = cout[r];
        end
        aclc_mix_col u_mix (.col_in(cin), .coef(coef), .col_out(cout));
    end

    // Final layer select and round-key addition.
    always_comb begin
        for (int i = 0; i < N_BYTES; i++)
            state_out[i] = (last ? shuf_b[i] : mix_b[i]) ^ rk_out[i];
    end
endmodule

// File: rtl/aclc_cipher_core.sv
// Top: iterative programmable block cipher, one round per cycle after a
// one-cycle whitening load. Assumes start is a single-cycle strobe.
module aclc_cipher_core
    import aclc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [7:0]   cfg_addr,
    input  logic [7:0]   cfg_data,
    output logic         cfg_err,
    input  logic         start,
    input  logic [127:0] plaintext,
    input  logic [127:0] key,
    output logic         busy,
    output logic         done,
    output logic [127:0] ciphertext
);
    byte_t             tbl  [TBL_DEPTH];
    logic [IDX_W-1:0]  dst  [N_BYTES];
    byte_t             coef [N_ROWS];
    byte_t             state_q [N_BYTES];
    byte_t             rk_q    [N_BYTES];
    byte_t             state_d [N_BYTES];
    byte_t             rk_d    [N_BYTES];
    logic [RND_W-1:0]  rnd_q;
    logic              busy_q, done_q, go, last;

    aclc_cfg_store u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .addr(cfg_addr),
        .data(cfg_data), .lock(busy_q), .tbl(tbl), .dst(dst), .coef(coef),
        .err(cfg_err)
    );

    assign last = (rnd_q == RND_W'(N_ROUNDS));
    assign go   = start && !busy_q && !cfg_err;

    aclc_round u_round (
        .state_in(state_q), .rk_in(rk_q), .tbl(tbl), .dst(dst), .coef(coef),
        .rnd(rnd_q), .last(last), .state_out(state_d), .rk_out(rk_d)
    );

    // Sequencer: round counter, busy and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                busy_q <= 1'b1;
                rnd_q  <= RND_W'(1);
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rnd_q  <= '0;
                end else begin
                    rnd_q <= rnd_q + RND_W'(1);
                end
            end
        end
    end

    // Datapath registers: whitening load on start, one round per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) begin
                state_q[i] <= '0;
                rk_q[i]    <= '0;
            end
        end else if (go) begin
            for (int i = 0; i < N_BYTES; i++) begin
                state_q[i] <= plaintext[127-8*i -: 8] ^ key[127-8*i -: 8];
                rk_q[i]    <= key[127-8*i -: 8];
            end
        end else if (busy_q) begin
            state_q <= state_d;
            rk_q    <= rk_d;
        end
    end

    // Output packing, byte 0 in the most significant position.
    always_comb begin
        for (int i = 0; i < N_BYTES; i++) ciphertext[127-8*i -: 8] = state_q[i];
    end

    assign busy = busy_q;
    assign done = done_q;

    p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ciphertext));
    p_start_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_err && !busy) |=> (!busy && $stable(ciphertext)));
    p_run_not_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
    p_round_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd_q >= RND_W'(1) && rnd_q <= RND_W'(N_ROUNDS)));
endmodule

// File: tb/aclc_cipher_core_test.sv
module aclc_cipher_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [7:0]   cfg_addr = '0;
    logic [7:0]   cfg_data = '0;
    logic         start = 1'b0;
    logic [127:0] plaintext = '0;
    logic [127:0] key = '0;
    logic         cfg_err, busy, done;
    logic [127:0] ciphertext;

    aclc_cipher_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_err(cfg_err),
        .start(start), .plaintext(plaintext), .key(key), .busy(busy),
        .done(done), .ciphertext(ciphertext)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit chk_en  = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [7:0]   m_tbl [256];
    int           m_dst [16];
    logic [7:0]   m_cf  [4];
    bit           m_zero, m_busy, m_done;
    int           m_cnt;
    logic [127:0] m_ct, m_pending;
    logic [7:0]   aes_sb [256];

    function automatic logic [7:0] fmul(logic [7:0] x, logic [7:0] y);
        int acc = 0;
        int a = x;
        for (int i = 0; i < 8; i++) begin
            if (y[i]) acc = acc ^ a;
            a = a << 1;
            if (a >= 256) a = a ^ 'h11b;
        end
        return acc[7:0];
    endfunction

    function automatic bit model_err();
        bit seen [16];
        bit bad = 1'b0;
        for (int i = 0; i < 16; i++) seen[i] = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (seen[m_dst[i]]) bad = 1'b1;
            seen[m_dst[i]] = 1'b1;
        end
        return bad || m_zero;
    endfunction

    function automatic logic [127:0] ref_encrypt(logic [127:0] p, logic [127:0] k);
        logic [7:0] rk [16];
        logic [7:0] s  [16];
        logic [7:0] t  [16];
        logic [7:0] w  [4];
        logic [7:0] rc = 8'h01;
        logic [127:0] out;
        for (int i = 0; i < 16; i++) begin
            rk[i] = k[127-8*i -: 8];
            s[i]  = p[127-8*i -: 8] ^ rk[i];
        end
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 4; i++) w[i] = m_tbl[rk[12 + (i + 1) % 4]];
            w[0] = w[0] ^ rc;
            rc = fmul(rc, 8'h02);
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 4; i++) begin
                    rk[4*c+i] = rk[4*c+i] ^ w[i];
                    w[i] = rk[4*c+i];
                end
            for (int i = 0; i < 16; i++) t[m_dst[i]] = m_tbl[s[i]];
            for (int c = 0; c < 4; c++)
                for (int row = 0; row < 4; row++) begin
                    if (r == 10) s[4*c+row] = t[4*c+row];
                    else begin
                        s[4*c+row] = 8'h00;
                        for (int j = 0; j < 4; j++)
                            s[4*c+row] = s[4*c+row] ^ fmul(m_cf[(j - row + 4) % 4], t[4*c+j]);
                    end
                end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[i];
        end
        for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
        return out;
    endfunction

    // Model update on each clock edge (behavioural, requirement-driven)
    always @(posedge clk) begin
        bit pre_busy, pre_err;
        chk_en <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_tbl[i] = i[7:0];
            for (int i = 0; i < 16; i++) m_dst[i] = i;
            m_cf[0] = 8'h02; m_cf[1] = 8'h03; m_cf[2] = 8'h01; m_cf[3] = 8'h01;
            m_zero = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_ct = '0;
        end else begin
            pre_busy = m_busy;
            pre_err  = model_err();
            m_done = 0;
            if (pre_busy) begin
                m_cnt++;
                if (m_cnt == 10) begin
                    m_busy = 0; m_done = 1; m_ct = m_pending;
                end
            end else if (start && !pre_err) begin
                m_busy = 1; m_cnt = 0;
                m_pending = ref_encrypt(plaintext, key);
                m_ct = plaintext ^ key;
            end
            if (cfg_we && !pre_busy) begin
                if (cfg_sel == 2'd0) m_tbl[cfg_addr] = cfg_data;
                else if (cfg_sel == 2'd1) m_dst[cfg_addr[3:0]] = cfg_data[3:0];
                else if (cfg_sel == 2'd2) begin
                    m_zero = (cfg_data == 8'h00);
                    if (cfg_data != 8'h00) m_cf[cfg_addr[1:0]] = cfg_data;
                end
            end
        end
    end

    // Comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            vectors++;
            if (busy !== m_busy || done !== m_done) begin
                errors++;
                $display("FAIL R8: busy/done = %b/%b expected %b/%b", busy, done, m_busy, m_done);
            end
            vectors++;
            if (cfg_err !== model_err()) begin
                errors++;
                $display("FAIL R7: cfg_err = %b expected %b", cfg_err, model_err());
            end
            if (!m_busy) begin
                vectors++;
                if (ciphertext !== m_ct) begin
                    errors++;
                    $display("FAIL %s: ciphertext = %h expected %h", cur_req, ciphertext, m_ct);
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic do_run(input logic [127:0] p, input logic [127:0] k, input string tag);
        cur_req = tag;
        @(negedge clk);
        plaintext = p; key = k; start = 1;
        @(negedge clk);
        start = 0;
        repeat (11) @(negedge clk);
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end

    initial begin
        // Standard table computed from field inverse plus affine map
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] b;
            for (int y = 1; y < 256; y++)
                if (x != 0 && fmul(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
            b = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                    ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
            aes_sb[x] = b;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state observed for a few idle cycles, then a run on reset config
        repeat (3) @(negedge clk);
        do_run(128'h0123456789abcdeffedcba9876543210, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, "R1");
        // R2: whitening and byte order with a different pattern
        do_run(128'hffffffff00000000aaaaaaaa55555555, 128'h00000000ffffffff5555555500000001, "R2");
        // R3: load the standard table; R4: load the row-shift shuffle
        cur_req = "R3";
        for (int i = 0; i < 256; i++) cfg_write(2'd0, i[7:0], aes_sb[i]);
        cur_req = "R4";
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                cfg_write(2'd1, 8'(4*c + r), 8'(r + 4*((c - r + 4) % 4)));
        do_run(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, "R9");
        vectors++;
        if (ciphertext !== 128'h69c4e0d86a7b0430d8cdb78070b4c55a) begin
            errors++;
            $display("FAIL R9: ciphertext = %h expected 69c4e0d86a7b0430d8cdb78070b4c55a", ciphertext);
        end
        // R5: custom coefficients
        cfg_write(2'd2, 8'd0, 8'h05);
        cfg_write(2'd2, 8'd1, 8'h07);
        cfg_write(2'd2, 8'd2, 8'h09);
        cfg_write(2'd2, 8'd3, 8'h0b);
        do_run(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, "R5");
        // R4: a non-trivial shuffle s -> (5s+3) mod 16
        for (int s = 0; s < 16; s++) cfg_write(2'd1, 8'(s), 8'((5*s + 3) % 16));
        do_run(128'hdeadbeef0badf00dcafebabe12345678, 128'h11223344556677880011223344556677, "R4");
        // R6: zero coefficient refused, error raised, start blocked
        cfg_write(2'd2, 8'd1, 8'h00);
        do_run(128'h1, 128'h2, "R6");
        cfg_write(2'd2, 8'd2, 8'h0d);
        do_run(128'habcdef, 128'h123456, "R6");
        // R7: duplicate destination blocks start, repair clears it
        cfg_write(2'd1, 8'd0, 8'((5*1 + 3) % 16));
        do_run(128'h77, 128'h88, "R7");
        cfg_write(2'd1, 8'd0, 8'd3);
        do_run(128'h77, 128'h88, "R7");
        // R10: writes and start during a run have no effect
        cur_req = "R10";
        @(negedge clk);
        plaintext = 128'h5a5a; key = 128'ha5a5; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        cfg_we = 1; cfg_sel = 2'd0; cfg_addr = 8'h00; cfg_data = 8'hee; start = 1;
        plaintext = 128'h9999;
        @(negedge clk);
        cfg_sel = 2'd2; cfg_addr = 8'd0; cfg_data = 8'h21;
        @(negedge clk);
        cfg_we = 0; start = 0;
        repeat (8) @(negedge clk);
        do_run(128'h0, 128'h0, "R10");
        // R8: start in the same cycle that done is seen
        cur_req = "R8";
        @(negedge clk);
        plaintext = 128'h4242; key = 128'h2424; start = 1;
        @(negedge clk);
        start = 0;
        repeat (9) @(negedge clk);
        start = 1; plaintext = 128'h1357;
        @(negedge clk);
        start = 0;
        repeat (14) @(negedge clk);
        finish_up();
    end
endmodule